// File: doc/BRIEF.md
# DDR Mode Register Programming Unit

This unit sits on the controller side of a DDR SDRAM interface and writes the memory's base mode register. A requester offers a burst length code, a burst ordering bit, a CAS latency code and a DLL-reset flag through a valid/ready handshake. The unit checks the codes and the array state in the same cycle. A legal request becomes one mode-register-set command on the command and address pins, with the fields packed into fixed address bits. Any other request is answered with a one-cycle error pulse, and no command reaches the pins.

After the command, the unit keeps its ready line low and drives idle (no-operation) commands until the register write has had time to settle. It then pulses a done flag and accepts the next request in that same cycle. The last value written is kept on an output, so the rest of the controller can read the burst length, ordering and latency in force. The register contents at power-up are undefined, so the controller must write it before any read or write traffic. The same sequence reprograms it later, whenever all banks are idle.

Top module: `ddr_mrs_prog`

## Requirements
- R1: While reset is held and in the first cycle after it, the pins carry a no-operation command (cmd_cs_n=0, cmd_ras_n=1, cmd_cas_n=1, cmd_we_n=1), mrs_done and mrs_err are 0, req_ready is 1 and mode_shadow is 0.
- R2: A legal request accepted at a clock edge (req_valid and req_ready both 1) drives, in the very next cycle and for that one cycle only, the mode-register-set command: cmd_cs_n, cmd_ras_n, cmd_cas_n and cmd_we_n all 0 and cmd_ba = 2'b00.
- R3: During that command, cmd_addr[2:0] carries the burst length code, bit 3 the burst ordering (0 sequential, 1 interleaved), bits 6:4 the CAS latency code, bit 7 is 0 (normal mode), bit 8 the DLL-reset flag and every bit above 8 is 0.
- R4: The only accepted burst length codes are 3'b001 (2 beats), 3'b010 (4 beats) and 3'b011 (8 beats); every other code is rejected.
- R5: The only accepted CAS latency codes are 3'b010 (2 cycles) and 3'b110 (2.5 cycles); every other code is rejected.
- R6: A request is rejected when any bit of bank_idle is 0 or cke_on is 0.
- R7: A rejected request gives mrs_err = 1 for exactly the cycle after acceptance. No command other than no-operation appears, mode_shadow keeps its value and req_ready stays 1.
- R8: After the command cycle, req_ready is 0 and no-operation is driven for WAIT_CYC-1 cycles. In the WAIT_CYC-th cycle after the command, mrs_done is 1 for one cycle and req_ready is 1 again.
- R9: mode_shadow takes the driven address value in the same cycle as the command and changes at no other time.
- R10: A request held valid through the wait is accepted in the done cycle, so its command follows done by exactly one cycle. Two commands are thus never closer than WAIT_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_bl | input | 3 | Burst length code |
| req_bt | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| req_cl | input | 3 | CAS latency code |
| req_dll_rst | input | 1 | Request a DLL reset with this write |
| bank_idle | input | NBANK | One bit per bank, 1 when the bank is precharged |
| cke_on | input | 1 | Clock enable to the memory is already high |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address pins |
| cmd_addr | output | ADDR_W | Address pins |
| mode_shadow | output | ADDR_W | Copy of the last value written |
| mrs_done | output | 1 | One-cycle pulse when the write has settled |
| mrs_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The done pulse at the end of one write and the acceptance of the next request can fall in the same cycle. The bench provokes this by keeping req_valid high with new fields through the whole wait. It first uses a legal second request, then an illegal one. In both cases it judges the outcome at the pins: the next command or error must come exactly one cycle after done. For a legal second request, the address must carry the new fields. For an illegal one, mode_shadow must still hold the first value. The done pulse must be neither lost nor repeated.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } mrs_state_e;

    // field positions a memory decodes; fixed by the device, not tunable
    localparam int BL_LSB   = 0;
    localparam int BT_BIT   = 3;
    localparam int CL_LSB   = 4;
    localparam int TM_BIT   = 7;
    localparam int DLL_BIT  = 8;
    localparam int USED_W   = 9;

    function automatic logic bl_code_ok(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

    function automatic logic cl_code_ok(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/mrs_req_check.sv
module mrs_req_check
    import mrs_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        bl,
    input  logic              bt,
    input  logic [2:0]        cl,
    input  logic              dll,
    input  logic [NBANK-1:0]  bank_idle,
    input  logic              cke_on,
    output logic              ok,
    output logic [ADDR_W-1:0] word
);
    localparam int RSV_W = ADDR_W - USED_W;

    logic codes_ok;
    logic array_ok;

    always_comb begin
        codes_ok = bl_code_ok(bl) && cl_code_ok(cl);
        array_ok = (&bank_idle) && cke_on;
        ok       = codes_ok && array_ok;
    end

    always_comb begin
        word[BL_LSB +: 3] = bl;
        word[BT_BIT]      = bt;
        word[CL_LSB +: 3] = cl;
        word[TM_BIT]      = 1'b0;
        word[DLL_BIT]     = dll;
    end

    generate
        if (RSV_W > 0) begin : g_rsv
            always_comb word[ADDR_W-1:USED_W] = '0;
        end
    endgenerate

endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
    import mrs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ok,
    input  logic [ADDR_W-1:0] req_word,
    output logic              req_ready,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] mode_shadow,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    typedef struct packed {
        mrs_state_e        st;
        logic [CNT_W-1:0]  cnt;
        cmd_t              cmd;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mode;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.cmd  = CMD_NOP;
        r_d.addr = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        r_d.st   = ST_WAIT;
                        r_d.cnt  = CNT_W'(WAIT_CYC - 1);
                        r_d.cmd  = CMD_MRS;
                        r_d.addr = req_word;
                        r_d.mode = req_word;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.cmd  <= CMD_NOP;
            r_q.addr <= '0;
            r_q.mode <= '0;
            r_q.done <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready   = (r_q.st == ST_IDLE);
        cmd         = r_q.cmd;
        cmd_addr    = r_q.addr;
        mode_shadow = r_q.mode;
        done        = r_q.done;
        err         = r_q.err;
    end

endmodule

// File: rtl/ddr_mrs_prog.sv
module ddr_mrs_prog
    import mrs_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int ADDR_W   = 12,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_bl,
    input  logic              req_bt,
    input  logic [2:0]        req_cl,
    input  logic              req_dll_rst,
    input  logic [NBANK-1:0]  bank_idle,
    input  logic              cke_on,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [1:0]        cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] mode_shadow,
    output logic              mrs_done,
    output logic              mrs_err
);
    logic              chk_ok;
    logic [ADDR_W-1:0] chk_word;
    cmd_t              cmd;

    mrs_req_check #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_check (
        .bl        (req_bl),
        .bt        (req_bt),
        .cl        (req_cl),
        .dll       (req_dll_rst),
        .bank_idle (bank_idle),
        .cke_on    (cke_on),
        .ok        (chk_ok),
        .word      (chk_word)
    );

    mrs_seq #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ok      (chk_ok),
        .req_word    (chk_word),
        .req_ready   (req_ready),
        .cmd         (cmd),
        .cmd_addr    (cmd_addr),
        .mode_shadow (mode_shadow),
        .done        (mrs_done),
        .err         (mrs_err)
    );

    always_comb begin
        cmd_cs_n  = cmd.cs_n;
        cmd_ras_n = cmd.ras_n;
        cmd_cas_n = cmd.cas_n;
        cmd_we_n  = cmd.we_n;
        cmd_ba    = 2'b00;
    end

endmodule

// File: rtl/mrs_chk.sv
module mrs_chk #(
    parameter int NBANK    = 4,
    parameter int ADDR_W   = 12,
    parameter int WAIT_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [NBANK-1:0]  bank_idle,
    input logic              cke_on,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [1:0]        cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [ADDR_W-1:0] mode_shadow,
    input logic              mrs_done,
    input logic              mrs_err
);
    localparam int GW = $clog2(WAIT_CYC + 2) + 1;

    logic mrs_now, nop_now;
    logic [GW-1:0] gap;
    logic seen;

    always_comb begin
        mrs_now = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;
        nop_now = !cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (mrs_now) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != {GW{1'b1}}) begin
            gap  <= gap + GW'(1);
        end
    end

    // R2
    mrs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |=> nop_now);
    // R2
    mrs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |-> $past(req_valid && req_ready));
    // R3
    mrs_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |-> (cmd_ba == 2'b00) && !cmd_addr[7] && ((cmd_addr >> 9) == '0));
    // R4
    mrs_bl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |-> (cmd_addr[2:0] == 3'd1) || (cmd_addr[2:0] == 3'd2) || (cmd_addr[2:0] == 3'd3));
    // R5
    mrs_cl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |-> (cmd_addr[6:4] == 3'd2) || (cmd_addr[6:4] == 3'd6));
    // R6
    mrs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |-> $past((&bank_idle) && cke_on));
    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_err |-> nop_now && !mrs_done && req_ready && $stable(mode_shadow));
    // R7
    err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_err |-> $past(req_valid && req_ready));
    // R8
    done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_done |-> seen && (int'(gap) == WAIT_CYC - 1) && req_ready);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_done |=> !mrs_done);
    // R9
    shadow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_now |-> mode_shadow == cmd_addr);
    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_now |-> $stable(mode_shadow));
    // R10
    mrs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_now && seen) |-> int'(gap) >= WAIT_CYC);

endmodule

bind ddr_mrs_prog mrs_chk #(.NBANK(NBANK), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bank_idle   (bank_idle),
    .cke_on      (cke_on),
    .cmd_cs_n    (cmd_cs_n),
    .cmd_ras_n   (cmd_ras_n),
    .cmd_cas_n   (cmd_cas_n),
    .cmd_we_n    (cmd_we_n),
    .cmd_ba      (cmd_ba),
    .cmd_addr    (cmd_addr),
    .mode_shadow (mode_shadow),
    .mrs_done    (mrs_done),
    .mrs_err     (mrs_err)
);

// File: tb/sim_ddr_mrs_prog.sv
module sim_ddr_mrs_prog;
    localparam int NBANK    = 4;
    localparam int ADDR_W   = 12;
    localparam int WAIT_CYC = 2;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_bl = '0;
    logic req_bt = 1'b0;
    logic [2:0] req_cl = '0;
    logic req_dll_rst = 1'b0;
    logic [NBANK-1:0] bank_idle = '1;
    logic cke_on = 1'b1;
    logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0] cmd_ba;
    logic [ADDR_W-1:0] cmd_addr, mode_shadow;
    logic mrs_done, mrs_err;

    int total = 0;
    int bad = 0;
    logic [ADDR_W-1:0] exp_mode = '0;

    always #10 clk = ~clk;

    ddr_mrs_prog #(.NBANK(NBANK), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bl(req_bl), .req_bt(req_bt), .req_cl(req_cl), .req_dll_rst(req_dll_rst),
        .bank_idle(bank_idle), .cke_on(cke_on),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .mode_shadow(mode_shadow),
        .mrs_done(mrs_done), .mrs_err(mrs_err)
    );

    function automatic logic [3:0] cmdv();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    function automatic logic [ADDR_W-1:0] pack(input int bl, input int bt, input int cl, input int dll);
        return ADDR_W'(bl + bt * 8 + cl * 16 + dll * 256);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic set_fields(input int bl, input int bt, input int cl, input int dll);
        req_bl = 3'(bl);
        req_bt = 1'(bt);
        req_cl = 3'(cl);
        req_dll_rst = 1'(dll);
    endtask

    task automatic do_req(input int bl, input int bt, input int cl, input int dll,
                          input logic [NBANK-1:0] idle, input logic cke);
        logic legal;
        logic [ADDR_W-1:0] w;
        @(negedge clk);
        set_fields(bl, bt, cl, dll);
        bank_idle = idle;
        cke_on = cke;
        req_valid = 1'b1;
        chk("R8", 32'(req_ready), 32'd1, "ready while idle");
        @(negedge clk);
        req_valid = 1'b0;
        legal = (bl >= 1 && bl <= 3) && (cl == 2 || cl == 6) && (idle == '1) && cke;
        w = pack(bl, bt, cl, dll);
        if (legal) begin
            chk("R2", 32'(cmdv()), 32'(MRS), "command");
            chk("R2", 32'(cmd_ba), 32'd0, "bank pins");
            chk("R3", 32'(cmd_addr), 32'(w), "address");
            chk("R9", 32'(mode_shadow), 32'(w), "shadow");
            chk("R7", 32'(mrs_err), 32'd0, "no error");
            exp_mode = w;
            for (int k = 1; k < WAIT_CYC; k++) begin
                @(negedge clk);
                chk("R8", 32'(cmdv()), 32'(NOP), "wait command");
                chk("R8", 32'(req_ready), 32'd0, "ready in wait");
                chk("R8", 32'(mrs_done), 32'd0, "done early");
            end
            @(negedge clk);
            chk("R8", 32'(mrs_done), 32'd1, "done pulse");
            chk("R8", 32'(req_ready), 32'd1, "ready at done");
            chk("R8", 32'(cmdv()), 32'(NOP), "command at done");
            @(negedge clk);
            chk("R8", 32'(mrs_done), 32'd0, "done width");
        end else begin
            if (!(bl >= 1 && bl <= 3)) begin
                chk("R4", 32'(mrs_err), 32'd1, "error on length code");
                chk("R4", 32'(cmdv()), 32'(NOP), "no command");
            end else if (!(cl == 2 || cl == 6)) begin
                chk("R5", 32'(mrs_err), 32'd1, "error on latency code");
                chk("R5", 32'(cmdv()), 32'(NOP), "no command");
            end else begin
                chk("R6", 32'(mrs_err), 32'd1, "error on busy bank or cke");
                chk("R6", 32'(cmdv()), 32'(NOP), "no command");
            end
            chk("R7", 32'(mode_shadow), 32'(exp_mode), "shadow kept");
            chk("R7", 32'(req_ready), 32'd1, "ready kept");
            @(negedge clk);
            chk("R7", 32'(mrs_err), 32'd0, "error width");
        end
        bank_idle = '1;
        cke_on = 1'b1;
    endtask

    task automatic back_to_back(input int bl2, input int cl2);
        logic legal2;
        logic [ADDR_W-1:0] wa, wb;
        wa = pack(2, 1, 6, 0);
        wb = pack(bl2, 0, cl2, 1);
        legal2 = (bl2 >= 1 && bl2 <= 3) && (cl2 == 2 || cl2 == 6);
        @(negedge clk);
        set_fields(2, 1, 6, 0);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R10", 32'(cmdv()), 32'(MRS), "first command");
        chk("R10", 32'(cmd_addr), 32'(wa), "first address");
        exp_mode = wa;
        set_fields(bl2, 0, cl2, 1);
        for (int k = 1; k < WAIT_CYC; k++) begin
            @(negedge clk);
            chk("R10", 32'(cmdv()), 32'(NOP), "held request waits");
            chk("R10", 32'(req_ready), 32'd0, "not ready");
        end
        @(negedge clk);
        chk("R10", 32'(mrs_done), 32'd1, "done with held request");
        chk("R10", 32'(cmdv()), 32'(NOP), "no command at done");
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", 32'(mrs_done), 32'd0, "done not repeated");
        if (legal2) begin
            chk("R10", 32'(cmdv()), 32'(MRS), "second command one after done");
            chk("R10", 32'(cmd_addr), 32'(wb), "second address");
            chk("R9", 32'(mode_shadow), 32'(wb), "shadow second");
            exp_mode = wb;
            for (int k = 0; k < WAIT_CYC; k++) @(negedge clk);
            chk("R8", 32'(mrs_done), 32'd1, "second done");
        end else begin
            chk("R10", 32'(mrs_err), 32'd1, "error one after done");
            chk("R7", 32'(cmdv()), 32'(NOP), "no second command");
            chk("R7", 32'(mode_shadow), 32'(wa), "shadow keeps first");
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 32'(cmdv()), 32'(NOP), "reset command");
        chk("R1", 32'(mrs_done), 32'd0, "reset done");
        chk("R1", 32'(mrs_err), 32'd0, "reset err");
        chk("R1", 32'(mode_shadow), 32'd0, "reset shadow");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(cmdv()), 32'(NOP), "after reset command");
        chk("R1", 32'(req_ready), 32'd1, "after reset ready");
        chk("R1", 32'(mode_shadow), 32'd0, "after reset shadow");

        for (int bl = 0; bl < 8; bl++)
            for (int bt = 0; bt < 2; bt++)
                for (int cl = 0; cl < 8; cl++)
                    for (int dll = 0; dll < 2; dll++)
                        do_req(bl, bt, cl, dll, '1, 1'b1);

        for (int m = 0; m < (1 << NBANK); m++)
            do_req(3, m % 2, 2, 0, NBANK'(m), 1'b1);
        do_req(1, 0, 6, 1, '1, 1'b0);
        do_req(2, 1, 2, 0, '1, 1'b0);

        back_to_back(3, 2);
        back_to_back(1, 6);
        back_to_back(4, 2);
        back_to_back(2, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule